// File: doc/BRIEF.md
# Configurable Memory Chip-Select Decoder

This block turns a 16-bit processor address into chip selects for three byte-wide memory sockets. A segment decoder splits the address space into eight 8K, four 16K or two 32K regions, chosen by a two-bit mode input. A small mapping register file then routes each of the eight decoder outputs to one socket, or to none. Coarser segment sizes are made by forcing the low decoder inputs high, so in 16K mode only the odd decoder outputs can fire, and in 32K mode only outputs 3 and 7 can.

Every select needs the active-low address strobe. Socket selects are also blocked by an active-low memory-disable input, which lets an off-board device take over a segment, and by an active-low power-good/reset input that protects battery-backed memory during a power fail. Two fixed selects are also produced: one for a four-byte display window at 0xB5FC to 0xB5FF and one for a keypad register at 0xB00A. Socket selects never fire inside these two windows. All selects are registered, and the mapping loads through a one-entry-per-cycle configuration port.

Top module: `mem_cs_decoder`

## Requirements
- R1: With seg_mode_i = 0 (8K), the decoder output index equals addr_i[15:13].
- R2: With seg_mode_i = 1 (16K), the index is {addr_i[15:14], 1}, so only outputs 1, 3, 5 and 7 are ever active.
- R3: With seg_mode_i = 2 (32K), the index is {addr_i[15], 1, 1}, so only outputs 3 and 7 are active. Code 3 behaves like code 2.
- R4: No select of any kind asserts unless as_ni is low.
- R5: memdis_ni low suppresses all socket selects. The display and keypad selects are not affected.
- R6: pwr_ok_ni low suppresses every select.
- R7: After reset the mapping is: outputs 0 to 4 go to socket 0, outputs 5 and 6 go to socket 1, and output 7 goes to socket 2.
- R8: disp_cs_o asserts for addresses 0xB5FC to 0xB5FF, and kpd_cs_o asserts for address 0xB00A. For these addresses no socket select asserts.
- R9: A socket select is active when any decoder output mapped to it is active. Mapping code 3 means the output is unconnected. At most one of sock_cs_o[2:0], disp_cs_o and kpd_cs_o is high at a time.
- R10: When cfg_we_i is high at a clock edge, the mapping entry cfg_idx_i takes the value cfg_code_i. The outputs registered at that same edge still use the old mapping; the new entry applies from the next edge on.
- R11: Outputs are registered: the values after an edge reflect the inputs sampled at that edge. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Processor address |
| as_ni | input | 1 | Address strobe, active low |
| memdis_ni | input | 1 | External memory disable, active low |
| pwr_ok_ni | input | 1 | Reset / low-voltage input; low blocks all selects |
| seg_mode_i | input | 2 | Segment size: 0 = 8K, 1 = 16K, 2 or 3 = 32K |
| cfg_we_i | input | 1 | Mapping entry write enable |
| cfg_idx_i | input | 3 | Decoder output whose mapping is written |
| cfg_code_i | input | 2 | Socket number 0 to 2, or 3 for unconnected |
| sock_cs_o | output | 3 | Socket chip selects, active high, registered |
| disp_cs_o | output | 1 | Display window select, registered |
| kpd_cs_o | output | 1 | Keypad register select, registered |

## Verification
The bench sweeps a dense grid of addresses in each mode, along with every byte around the two fixed windows, and compares the result with an arithmetic segment model. A wrong forcing mask would show up as even decoder outputs firing in 16K mode, or as a socket select inside the display window. Strobe, memory-disable and power-fail gating are each toggled on their own. A design that let memory-disable also block the display would lose disp_cs_o. A remapped table with an unconnected output, and a write made in the same cycle as a lookup, catch OR-merging errors and an off-by-one in the mapping's latency.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int ADDR_W   = 16;
  localparam int SEG_W    = 3;
  localparam int NUM_SEG  = 1 << SEG_W;
  localparam int NUM_SOCK = 3;
  localparam int MAP_W    = 2;

  typedef enum logic [1:0] {
    SEG_8K  = 2'd0,
    SEG_16K = 2'd1,
    SEG_32K = 2'd2,
    SEG_32X = 2'd3
  } seg_mode_e;

  typedef logic [MAP_W-1:0] sock_code_t;
  localparam sock_code_t SOCK_NONE = sock_code_t'(3);

  function automatic sock_code_t default_code(int seg);
    if (seg <= 4)      return sock_code_t'(0);
    else if (seg <= 6) return sock_code_t'(1);
    else               return sock_code_t'(2);
  endfunction
endpackage

// File: rtl/mcs_seg_index.sv
module mcs_seg_index
  import mcs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        seg_mode_i,
  output logic [SEG_W-1:0]  idx_o
);
  logic [SEG_W-1:0] force_mask;

  // coarser segments: force low decoder inputs high
  always_comb begin
    case (seg_mode_e'(seg_mode_i))
      SEG_8K:  force_mask = '0;
      SEG_16K: force_mask = SEG_W'(1);
      default: force_mask = SEG_W'(3);
    endcase
  end

  assign idx_o = addr_i[ADDR_W-1 -: SEG_W] | force_mask;
endmodule

// File: rtl/mcs_map_regs.sv
module mcs_map_regs
  import mcs_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [SEG_W-1:0]                idx_i,
  input  logic [MAP_W-1:0]                code_i,
  output logic [NUM_SEG-1:0][MAP_W-1:0]   map_o
);
  for (genvar i = 0; i < NUM_SEG; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          map_o[i] <= default_code(i);
      else if (we_i && idx_i == SEG_W'(i))  map_o[i] <= code_i;
    end
  end

  // R10
  map_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> map_o[$past(idx_i)] == $past(code_i));
endmodule

// File: rtl/mcs_sock_route.sv
module mcs_sock_route
  import mcs_pkg::*;
(
  input  logic [NUM_SEG-1:0]              dec_hot_i,
  input  logic [NUM_SEG-1:0][MAP_W-1:0]   map_i,
  output logic [NUM_SOCK-1:0]             sock_o
);
  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
    logic [NUM_SEG-1:0] hit;
    for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
      assign hit[i] = dec_hot_i[i] && (map_i[i] == MAP_W'(s));
    end
    assign sock_o[s] = |hit;
  end
endmodule

// File: rtl/mem_cs_decoder.sv
module mem_cs_decoder
  import mcs_pkg::*;
#(
  parameter logic [15:0] DISP_BASE = 16'hB5FC,
  parameter int          DISP_LOG2 = 2,
  parameter logic [15:0] KPD_ADDR  = 16'hB00A
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [15:0]         addr_i,
  input  logic                as_ni,
  input  logic                memdis_ni,
  input  logic                pwr_ok_ni,
  input  logic [1:0]          seg_mode_i,
  input  logic                cfg_we_i,
  input  logic [2:0]          cfg_idx_i,
  input  logic [1:0]          cfg_code_i,
  output logic [2:0]          sock_cs_o,
  output logic                disp_cs_o,
  output logic                kpd_cs_o
);
  localparam int WIN_W = ADDR_W - DISP_LOG2;

  logic [SEG_W-1:0]            seg_idx;
  logic [NUM_SEG-1:0][MAP_W-1:0] seg_map;
  logic [NUM_SEG-1:0]          dec_hot;
  logic [NUM_SOCK-1:0]         sock_nxt;
  logic in_disp, in_kpd, bus_ok, dec_en, seen_q;

  mcs_seg_index u_idx (
    .addr_i     (addr_i),
    .seg_mode_i (seg_mode_i),
    .idx_o      (seg_idx)
  );

  mcs_map_regs u_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .idx_i  (cfg_idx_i),
    .code_i (cfg_code_i),
    .map_o  (seg_map)
  );

  assign in_disp = addr_i[ADDR_W-1 -: WIN_W] == DISP_BASE[ADDR_W-1 -: WIN_W];
  assign in_kpd  = addr_i == KPD_ADDR;
  assign bus_ok  = !as_ni && pwr_ok_ni;
  assign dec_en  = bus_ok && memdis_ni && !in_disp && !in_kpd;
  assign dec_hot = dec_en ? (NUM_SEG'(1) << seg_idx) : '0;

  mcs_sock_route u_route (
    .dec_hot_i (dec_hot),
    .map_i     (seg_map),
    .sock_o    (sock_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sock_cs_o <= '0;
      disp_cs_o <= 1'b0;
      kpd_cs_o  <= 1'b0;
      seen_q    <= 1'b0;
    end else begin
      sock_cs_o <= sock_nxt;
      disp_cs_o <= bus_ok && in_disp;
      kpd_cs_o  <= bus_ok && in_kpd;
      seen_q    <= 1'b1;
    end
  end

  // R4
  no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(as_ni) |-> (sock_cs_o == '0 && !disp_cs_o && !kpd_cs_o));
  // R5
  memdis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(memdis_ni) |-> sock_cs_o == '0);
  // R6
  pwr_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pwr_ok_ni) |-> (sock_cs_o == '0 && !disp_cs_o && !kpd_cs_o));
  // R9
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sock_cs_o, disp_cs_o, kpd_cs_o}));
  // R2
  mode16_odd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_mode_i == SEG_16K) |-> (dec_hot & 8'h55) == '0);
  // R3
  mode32_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_mode_i[1] |-> (dec_hot & 8'h77) == '0);
  // R8
  disp_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(!as_ni && pwr_ok_ni && addr_i[15:2] == 14'h2D7F))
      |-> (disp_cs_o && sock_cs_o == '0));
endmodule

// File: tb/tb_mem_cs_decoder.sv
module tb_mem_cs_decoder;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic        as_n = 1'b1, md_n = 1'b1, pw_n = 1'b1;
  logic [1:0]  mode = 2'd0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [1:0]  cfg_code = '0;
  logic [2:0]  sock;
  logic        disp, kpd;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [1:0] tb_map [8];

  always #10 clk = ~clk;

  mem_cs_decoder dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .as_ni(as_n),
    .memdis_ni(md_n), .pwr_ok_ni(pw_n), .seg_mode_i(mode),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_code_i(cfg_code),
    .sock_cs_o(sock), .disp_cs_o(disp), .kpd_cs_o(kpd)
  );

  function automatic logic [4:0] model(logic [15:0] a, logic [1:0] m_in,
                                       logic asn, logic mdn, logic pwn);
    logic ok, dh, kh;
    int m, idx;
    logic [2:0] s;
    ok = !asn && pwn;
    dh = (a >= 16'hB5FC) && (a <= 16'hB5FF);
    kh = (a == 16'hB00A);
    m = (m_in == 2'd3) ? 2 : int'(m_in);
    idx = (((int'(a) >> (13 + m)) + 1) << m) - 1;
    s = '0;
    if (ok && mdn && !dh && !kh && tb_map[idx] != 2'd3) s[tb_map[idx]] = 1'b1;
    return {s, ok && dh, ok && kh};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect5(string req, logic [4:0] exp);
    n_chk++;
    if ({sock, disp, kpd} !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h mode=%0d got=%b exp=%b", req, addr, mode,
               {sock, disp, kpd}, exp);
    end
  endtask

  task automatic probe(string req, logic [15:0] a);
    addr = a;
    step();
    expect5(req, model(a, mode, as_n, md_n, pw_n));
    n_chk++;
    if ($countones({sock, disp, kpd}) > 1) begin
      n_fail++;
      $display("FAIL R9 overlap addr=%h got=%b exp=onehot0", a, {sock, disp, kpd});
    end
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < 1024; i++) probe(req, 16'((i << 6) | (i & 63)));
    for (int j = 0; j < 16; j++) probe("R8", 16'hB5F8 + 16'(j));
    for (int j = 0; j < 16; j++) probe("R8", 16'hB000 + 16'(j));
  endtask

  task automatic cfg_write(logic [2:0] i, logic [1:0] c);
    cfg_we = 1'b1; cfg_idx = i; cfg_code = c;
    step();
    cfg_we = 1'b0;
    tb_map[i] = c;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) tb_map[i] = (i <= 4) ? 2'd0 : (i <= 6) ? 2'd1 : 2'd2;
    as_n = 1'b0;
    addr = 16'h0000;
    repeat (3) @(negedge clk);
    // R11 reset clears outputs
    expect5("R11", 5'b0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R7 default map, R1 8K
    as_n = 1'b0;
    mode = 2'd0; sweep("R1");
    mode = 2'd1; sweep("R2");
    mode = 2'd2; sweep("R3");
    mode = 2'd3; sweep("R3");

    // R4 no strobe
    mode = 2'd0; as_n = 1'b1;
    probe("R4", 16'h2000); probe("R4", 16'hB5FD); probe("R4", 16'hB00A);
    as_n = 1'b0;
    // R5 memdis blocks sockets only
    md_n = 1'b0;
    probe("R5", 16'h0100); probe("R5", 16'hE000);
    addr = 16'hB5FE; step(); expect5("R5", 5'b00010);
    addr = 16'hB00A; step(); expect5("R5", 5'b00001);
    md_n = 1'b1;
    // R6 power fail blocks all
    pw_n = 1'b0;
    addr = 16'hB5FC; step(); expect5("R6", 5'b0);
    addr = 16'hA000; step(); expect5("R6", 5'b0);
    pw_n = 1'b1;
    // R11 one-cycle latency
    addr = 16'hE000; step(); expect5("R11", 5'b10000);
    addr = 16'h0000; expect5("R11", 5'b10000);

    // R10 write in same cycle as lookup: old map this edge, new next
    mode = 2'd0; addr = 16'h0000;
    cfg_we = 1'b1; cfg_idx = 3'd0; cfg_code = 2'd1;
    step();
    cfg_we = 1'b0;
    expect5("R10", 5'b00100);
    tb_map[0] = 2'd1;
    step();
    expect5("R10", 5'b01000);

    // R9 remap: output 7 unconnected, 3 to socket 2, 1 to socket 1
    cfg_write(3'd7, 2'd3);
    cfg_write(3'd3, 2'd2);
    cfg_write(3'd1, 2'd1);
    mode = 2'd0; sweep("R9");
    mode = 2'd1; sweep("R9");
    mode = 2'd2; sweep("R9");
    addr = 16'hF000; step(); expect5("R9", 5'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule